// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a parameterized number of interrupt lines (32 by default, up to 240) and one non-maskable input. It presents a single request with an 8-bit interrupt number to a processor core. Each line has an enable bit, a pending bit, an active bit, a capture mode and an 8-bit priority. The priority value is inverted: 0 is the most urgent and 255 the least. Among the lines that are both pending and enabled, the controller offers the most urgent one. The core accepts the offered interrupt with an acknowledge strobe and reports the end of a handler with a completion strobe that carries the handler's number.

Software reaches the state through a synchronous word-addressed register bus. A write takes effect at the clock edge on which `bus_wr_en` is high. Read data is combinational on `bus_addr`. Enable and pending bits each have a pair of registers: writing a 1 to the set register sets the bit, and writing a 1 to the clear register clears it. A write-only trigger register pends a line by number. A split register divides each priority into a group field, which decides preemption, and a subpriority field, which only orders candidates.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all enable, pending, active, mode, priority and split state is zero, and `cpu_req` is low.
- R2: The 8-word regions start at these word addresses: set-enable at 0x00, clear-enable at 0x08, set-pending at 0x10 and clear-pending at 0x18. Word w holds lines 32w to 32w+31, with line 32w+k at bit k. Writing a 1 to a bit sets or clears the matching state bit, and a 0 bit has no effect. Reading either address of a pair returns the current state.
- R3: Priorities occupy word addresses 0x30 to 0x6B. Word p holds line 4p+b in bits 8b+7:8b. Priority words are readable, can be rewritten while lines are pending, and a rewrite changes the selection on the next cycle.
- R4: A write to word address 0x6D makes the line numbered in bits 7:0 pending. A number at or above the line count is ignored. Reading 0x6D returns zero.
- R5: `cpu_req` offers the pending and enabled line with the lowest priority value. On equal values the lowest line number wins. A pending line that is disabled is never offered.
- R6: An acknowledge while a line is offered clears that line's pending bit and sets its active bit. The active bits are readable at word address 0x20 and up.
- R7: Word address 0x6C bits 2:0 give the number of low priority bits that form the subpriority. The remaining high bits form the group. While a handler is active, a line is offered only if its group value is strictly below the lowest group value among the active lines.
- R8: A line whose mode bit is 0 is level-sensitive. It becomes pending while its input is high and the line is not active. If the input is still high at completion, the line pends again one cycle after the active bit drops.
- R9: A line whose mode bit is 1 is edge-sensitive; the mode bits sit at word address 0x28 and up. Each rising edge of its input sets pending once. Clearing the pending bit while the input stays high leaves it clear.
- R10: A rising edge on `nmi_in` raises a request with number 255 on the next cycle, ahead of every line and regardless of enables. While that request is active, no line is offered.
- R11: If a completion leaves a qualifying line pending, that line is offered in the very next cycle (tail-chaining).
- R12: A completion strobe clears the active bit of the number in `cpu_done_id`. The number 255 ends the non-maskable handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_in | input | NUM_LINES | Interrupt inputs |
| nmi_in | input | 1 | Non-maskable interrupt input |
| cpu_req | output | 1 | Interrupt request to the core |
| cpu_id | output | 8 | Number of the offered interrupt (255 for non-maskable) |
| cpu_ack | input | 1 | Core accepts the offered interrupt |
| cpu_done | input | 1 | Handler completion strobe |
| cpu_done_id | input | 8 | Number of the completed handler |

## Verification
Selection is tried with several patterns, each of which separates a different faulty decision:
- Two enabled lines with distinct priorities show whether the comparison runs in the correct direction.
- A priority rewrite on a pending line shows whether reordering is dynamic.
- Equal priorities expose the tie rule.
- A pending but disabled line shows the enable gating.

Preemption is tried with a line whose full value is more urgent, first under an all-group split and then under a split in which only the subpriority differs. This separates group-only comparison from full comparison.

Level, edge, non-maskable and completion-time patterns separate re-pending from single capture. They also show that the request follows a completion with no idle cycle.

// File: rtl/pvic_pkg.sv
// Package: shared constants for the prioritized interrupt controller.
// Assumes a word-addressed register bus of 7 address bits.
package pvic_pkg;
    localparam int PRIO_W  = 8;
    localparam int ID_W    = 8;
    localparam int ADDR_W  = 7;
    localparam int PAD_LINES = 256;

    localparam logic [ID_W-1:0] NMI_ID = 8'hFF;

    // Word address bases of the register regions
    localparam int A_EN_SET = 'h00;
    localparam int A_EN_CLR = 'h08;
    localparam int A_PD_SET = 'h10;
    localparam int A_PD_CLR = 'h18;
    localparam int A_ACT    = 'h20;
    localparam int A_MODE   = 'h28;
    localparam int A_PRIO   = 'h30;
    localparam int N_PRIO_W = 60;
    localparam int A_SPLIT  = 'h6C;
    localparam int A_TRIG   = 'h6D;

    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/pvic_capture.sv
// Module: per-line input capture.
// Turns each raw input into a one-cycle pending-set request. A line in edge
// mode fires once per rising edge. A line in level mode fires every cycle
// while its input is high and the line is neither active nor being
// acknowledged. Assumes the inputs are already synchronous to clk.
module pvic_capture #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] busy,
    output logic [N-1:0] set_req
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        // Remember the previous input level for edge detection
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= irq_in[g];
        end

        // Choose the edge or level rule for this line
        always_comb begin
            if (edge_mode[g]) set_req[g] = irq_in[g] & ~prev_q[g];
            else              set_req[g] = irq_in[g] & ~busy[g];
        end

        // An edge-mode line never requests on two cycles in a row
        p_edge_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_mode[g] && set_req[g]) |=> !(edge_mode[g] && set_req[g]));
    end
endmodule

// File: rtl/pvic_arbiter.sv
// Module: minimum-key selector.
// Among the valid entries it finds the smallest key, and on equal keys the
// lowest index. It is used both for candidate selection and for the running
// group of the active handlers. Purely combinational; the clock and reset
// serve only the assertions.
module pvic_arbiter #(
    parameter int N  = 32,
    parameter int KW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][KW-1:0] keys,
    output logic                 found,
    output logic [7:0]           idx,
    output logic [KW-1:0]        key
);
    // Linear scan; the strict compare keeps the lowest index on ties
    always_comb begin
        found = 1'b0;
        idx   = '0;
        key   = '1;
        for (int i = 0; i < N; i++) begin
            if (valid[i] && (!found || keys[i] < key)) begin
                found = 1'b1;
                idx   = 8'(i);
                key   = keys[i];
            end
        end
    end

    p_found_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
        found == (|valid));
    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (idx < 8'(N)));
endmodule

// File: rtl/pvic_regs.sv
// Module: register file and per-line state.
// Holds the enable, pending, active, mode and priority state and the group
// split. It applies bus writes, captured input events, acknowledges and
// completions, and decodes reads. Assumes at most one bus write per cycle
// and that N is at most 240.
module pvic_regs
    import pvic_pkg::*;
#(
    parameter int N = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [N-1:0]       cap_set,
    input  logic [N-1:0]       ack_vec,
    input  logic [N-1:0]       done_vec,
    output logic [N-1:0]       en_o,
    output logic [N-1:0]       pend_o,
    output logic [N-1:0]       act_o,
    output logic [N-1:0]       mode_o,
    output logic [N-1:0][7:0]  prio_o,
    output logic [2:0]         split_o
);
    logic [N-1:0]      en_q, pend_q, act_q, mode_q;
    logic [N-1:0]      en_n, pend_n, act_n, mode_n;
    logic [N-1:0][7:0] prio_q, prio_n;
    logic [2:0]        split_q;

    logic [PAD_LINES-1:0]      en_pad, pend_pad, act_pad, mode_pad;
    logic [PAD_LINES-1:0][7:0] prio_pad;
    logic [5:0]                pw;

    // Next state for each line from writes, capture, acknowledge and completion
    always_comb begin
        en_n   = en_q;
        pend_n = pend_q;
        act_n  = act_q;
        mode_n = mode_q;
        prio_n = prio_q;
        for (int i = 0; i < N; i++) begin
            if (we && addr == 7'(A_EN_SET + i / 32) && wdata[i % 32]) en_n[i] = 1'b1;
            if (we && addr == 7'(A_EN_CLR + i / 32) && wdata[i % 32]) en_n[i] = 1'b0;
            if (we && addr == 7'(A_PD_CLR + i / 32) && wdata[i % 32]) pend_n[i] = 1'b0;
            if (ack_vec[i]) pend_n[i] = 1'b0;
            if (we && addr == 7'(A_PD_SET + i / 32) && wdata[i % 32]) pend_n[i] = 1'b1;
            if (we && addr == 7'(A_TRIG) && wdata[7:0] == 8'(i)) pend_n[i] = 1'b1;
            if (cap_set[i]) pend_n[i] = 1'b1;
            if (done_vec[i]) act_n[i] = 1'b0;
            if (ack_vec[i])  act_n[i] = 1'b1;
            if (we && addr == 7'(A_MODE + i / 32)) mode_n[i] = wdata[i % 32];
            if (we && addr == 7'(A_PRIO + i / 4)) prio_n[i] = wdata[8 * (i % 4) +: 8];
        end
    end

    // State registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            pend_q  <= '0;
            act_q   <= '0;
            mode_q  <= '0;
            prio_q  <= '0;
            split_q <= '0;
        end else begin
            en_q   <= en_n;
            pend_q <= pend_n;
            act_q  <= act_n;
            mode_q <= mode_n;
            prio_q <= prio_n;
            if (we && addr == 7'(A_SPLIT)) split_q <= wdata[2:0];
        end
    end

    // Zero-extend the state to the widest line count for read indexing
    always_comb begin
        en_pad   = '0;
        pend_pad = '0;
        act_pad  = '0;
        mode_pad = '0;
        prio_pad = '0;
        for (int i = 0; i < N; i++) begin
            en_pad[i]   = en_q[i];
            pend_pad[i] = pend_q[i];
            act_pad[i]  = act_q[i];
            mode_pad[i] = mode_q[i];
            prio_pad[i] = prio_q[i];
        end
    end

    // Read decode for every region
    always_comb begin
        rdata = '0;
        pw    = 6'(addr - 7'(A_PRIO));
        if (addr < 7'(A_PRIO)) begin
            unique case (addr[5:3])
                3'd0, 3'd1: rdata = en_pad[{addr[2:0], 5'd0} +: 32];
                3'd2, 3'd3: rdata = pend_pad[{addr[2:0], 5'd0} +: 32];
                3'd4:       rdata = act_pad[{addr[2:0], 5'd0} +: 32];
                3'd5:       rdata = mode_pad[{addr[2:0], 5'd0} +: 32];
                default:    rdata = '0;
            endcase
        end else if (addr < 7'(A_PRIO + N_PRIO_W)) begin
            for (int b = 0; b < 4; b++) rdata[8 * b +: 8] = prio_pad[{pw, 2'(b)}];
        end else if (addr == 7'(A_SPLIT)) begin
            rdata = {29'd0, split_q};
        end
    end

    assign en_o    = en_q;
    assign pend_o  = pend_q;
    assign act_o   = act_q;
    assign mode_o  = mode_q;
    assign prio_o  = prio_q;
    assign split_o = split_q;

    // A trigger write to an existing line leaves that line pending
    p_trig_pends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 7'(A_TRIG) && wdata[7:0] < 8'(N)) |=> pend_pad[$past(wdata[7:0])]);
    // A clear-enable write leaves none of the written bits set
    p_clr_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 7'(A_EN_CLR)) |=> ((en_pad[31:0] & $past(wdata)) == 32'd0));
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: top of the prioritized interrupt controller.
// Combines capture, register state, candidate selection, running-group
// tracking and the non-maskable path into one request toward the core.
// Assumes the core acknowledges only while cpu_req is high and reports
// completions with the number it acknowledged.
module irq_prio_ctrl
    import pvic_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_en,
    input  logic [6:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 nmi_in,
    output logic                 cpu_req,
    output logic [7:0]           cpu_id,
    input  logic                 cpu_ack,
    input  logic                 cpu_done,
    input  logic [7:0]           cpu_done_id
);
    localparam int N = NUM_LINES;

    logic [N-1:0]      en, pend, act, mode, cap_set, ack_vec, done_vec, busy, cand_v;
    logic [N-1:0][7:0] prio, prio_grp;
    logic [2:0]        split;
    logic [7:0]        gmask;
    logic              cand_found, run_found;
    logic [7:0]        cand_idx, run_idx, cand_key, run_key;
    logic              nmi_prev_q, nmi_pend_q, nmi_act_q;
    logic              nmi_want, line_ok, ack_line, ack_nmi;
    logic [PAD_LINES-1:0] act_pad;

    pvic_capture #(.N(N)) u_capture (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .edge_mode(mode),
        .busy(busy), .set_req(cap_set)
    );

    pvic_regs #(.N(N)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .cap_set(cap_set),
        .ack_vec(ack_vec), .done_vec(done_vec), .en_o(en), .pend_o(pend),
        .act_o(act), .mode_o(mode), .prio_o(prio), .split_o(split)
    );

    // Group mask from the split and the masked priority of each line
    always_comb begin
        gmask = 8'hFF << split;
        for (int i = 0; i < N; i++) prio_grp[i] = prio[i] & gmask;
        cand_v = pend & en;
    end

    pvic_arbiter #(.N(N), .KW(8)) u_cand (
        .clk(clk), .rst_n(rst_n), .valid(cand_v), .keys(prio),
        .found(cand_found), .idx(cand_idx), .key(cand_key)
    );

    pvic_arbiter #(.N(N), .KW(8)) u_run (
        .clk(clk), .rst_n(rst_n), .valid(act), .keys(prio_grp),
        .found(run_found), .idx(run_idx), .key(run_key)
    );

    // Request decision: non-maskable first, then a line that may preempt
    always_comb begin
        nmi_want = nmi_pend_q && !nmi_act_q;
        line_ok  = cand_found && !nmi_act_q &&
                   (!run_found || ((cand_key & gmask) < run_key));
        cpu_req  = nmi_want || line_ok;
        cpu_id   = nmi_want ? NMI_ID : cand_idx;
        ack_nmi  = cpu_ack && nmi_want;
        ack_line = cpu_ack && !nmi_want && line_ok;
    end

    // Per-line acknowledge, completion and capture-blocking vectors
    always_comb begin
        for (int i = 0; i < N; i++) begin
            ack_vec[i]  = ack_line && cand_idx == 8'(i);
            done_vec[i] = cpu_done && cpu_done_id == 8'(i);
        end
        busy = act | ack_vec;
    end

    // Non-maskable edge capture and in-service flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev_q <= 1'b0;
            nmi_pend_q <= 1'b0;
            nmi_act_q  <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_in;
            if (ack_nmi) nmi_pend_q <= 1'b0;
            if (nmi_in && !nmi_prev_q) nmi_pend_q <= 1'b1;
            if (cpu_done && cpu_done_id == NMI_ID) nmi_act_q <= 1'b0;
            if (ack_nmi) nmi_act_q <= 1'b1;
        end
    end

    // Widened active vector for assertion indexing
    always_comb begin
        act_pad = '0;
        for (int i = 0; i < N; i++) act_pad[i] = act[i];
    end

    p_ack_activates_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_req && cpu_id != NMI_ID && !(cpu_done && cpu_done_id == cpu_id))
        |=> act_pad[$past(cpu_id)]);
    p_done_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cpu_done_id < 8'(N) && !cpu_ack) |=> !act_pad[$past(cpu_done_id)]);
    p_nmi_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_act_q && !cpu_ack && $rose(nmi_in)) |=> (cpu_req && cpu_id == NMI_ID));
    p_nmi_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_act_q && cpu_req) |-> cpu_id == NMI_ID);
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
    localparam int N = 32;
    localparam logic [6:0] EN_SET = 7'h00, EN_CLR = 7'h08, PD_SET = 7'h10,
                           PD_CLR = 7'h18, ACT = 7'h20, MODE = 7'h28,
                           PRIO0 = 7'h30, SPLIT = 7'h6C, TRIG = 7'h6D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr_en = 1'b0;
    logic [6:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_in = '0;
    logic nmi_in = 1'b0;
    logic cpu_req;
    logic [7:0] cpu_id;
    logic cpu_ack = 1'b0;
    logic cpu_done = 1'b0;
    logic [7:0] cpu_done_id = '0;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    item_t it;
    logic [31:0] act_v;

    always #2 clk = ~clk;

    irq_prio_ctrl #(.NUM_LINES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .nmi_in(nmi_in), .cpu_req(cpu_req), .cpu_id(cpu_id), .cpu_ack(cpu_ack),
        .cpu_done(cpu_done), .cpu_done_id(cpu_done_id)
    );

    // Monitor: pops expected items shortly after each falling edge
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.kind)
                0:       act_v = bus_rdata;
                1:       act_v = {31'd0, cpu_req};
                default: act_v = {24'd0, cpu_id};
            endcase
            checks++;
            if (act_v !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, act_v, it.exp);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        sb_q.push_back('{0, e, tag});
        @(negedge clk);
    endtask

    task automatic exp_req(input logic r, input logic [7:0] id, input string tag);
        sb_q.push_back('{1, {31'd0, r}, tag});
        if (r) sb_q.push_back('{2, {24'd0, id}, tag});
    endtask

    task automatic ack();
        @(negedge clk);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
    endtask

    task automatic done(input logic [7:0] id);
        @(negedge clk);
        cpu_done    = 1'b1;
        cpu_done_id = id;
        @(negedge clk);
        cpu_done = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        // R1 reset state
        exp_req(1'b0, 8'd0, "R1 req after reset");
        rd(EN_SET, 32'h0, "R1 enable reset");
        rd(PD_SET, 32'h0, "R1 pending reset");
        rd(ACT, 32'h0, "R1 active reset");
        rd(PRIO0, 32'h0, "R1 priority reset");
        // R2 set/clear pairs
        wr(EN_SET, 32'h0000_000F);
        rd(EN_SET, 32'hF, "R2 set-enable");
        rd(EN_CLR, 32'hF, "R2 clear-enable reads state");
        wr(EN_CLR, 32'h5);
        rd(EN_SET, 32'hA, "R2 clear-enable");
        wr(EN_SET, 32'h0);
        rd(EN_SET, 32'hA, "R2 zero write no effect");
        // R3 priority packing
        wr(PRIO0, 32'h4433_2211);
        rd(PRIO0, 32'h4433_2211, "R3 priority word");
        rd(PRIO0 + 7'd1, 32'h0, "R3 other word");
        exp_req(1'b0, 8'd0, "R5 nothing pending");
        // R4 software trigger
        wr(TRIG, 32'd0);
        rd(PD_SET, 32'h1, "R4 trigger pends line 0");
        exp_req(1'b0, 8'd0, "R5 disabled line not offered");
        rd(TRIG, 32'h0, "R4 trigger reads zero");
        wr(TRIG, 32'd40);
        rd(PD_SET, 32'h1, "R4 out-of-range number ignored");
        wr(PD_CLR, 32'h1);
        rd(PD_CLR, 32'h0, "R2 clear-pending");
        // R5 selection
        wr(PD_SET, 32'hA);
        exp_req(1'b1, 8'd1, "R5 lower value wins");
        wr(PRIO0, 32'h1033_2211);
        exp_req(1'b1, 8'd3, "R3 dynamic reprioritization");
        wr(PRIO0, 32'h1033_1011);
        exp_req(1'b1, 8'd1, "R5 tie lowest number");
        // R6 acknowledge
        ack();
        rd(ACT, 32'h2, "R6 active set");
        rd(PD_SET, 32'h8, "R6 pending cleared");
        exp_req(1'b0, 8'd0, "R7 equal group no preempt");
        // R7 preemption by group
        wr(PRIO0, 32'h0833_1011);
        exp_req(1'b1, 8'd3, "R7 more urgent group preempts");
        wr(SPLIT, 32'd5);
        exp_req(1'b0, 8'd0, "R7 subpriority only no preempt");
        // R11/R12 completion and tail-chain
        done(8'd1);
        exp_req(1'b1, 8'd3, "R11 tail-chain next cycle");
        rd(ACT, 32'h0, "R12 completion clears active");
        ack();
        exp_req(1'b0, 8'd0, "R6 nothing left");
        done(8'd3);
        rd(ACT, 32'h0, "R12 second completion");
        wr(SPLIT, 32'd0);
        // R8 level capture
        wr(EN_SET, 32'h20);
        irq_in[5] = 1'b1;
        tick();
        exp_req(1'b1, 8'd5, "R8 level pends");
        ack();
        exp_req(1'b0, 8'd0, "R8 no re-pend while active");
        done(8'd5);
        tick();
        exp_req(1'b1, 8'd5, "R8 re-pend after completion");
        irq_in[5] = 1'b0;
        wr(PD_CLR, 32'h20);
        rd(PD_SET, 32'h0, "R8 cleared after release");
        // R9 edge capture
        wr(MODE, 32'h40);
        wr(EN_SET, 32'h40);
        irq_in[6] = 1'b1;
        tick();
        exp_req(1'b1, 8'd6, "R9 edge pends");
        wr(PD_CLR, 32'h40);
        rd(PD_SET, 32'h0, "R9 held input no re-pend");
        exp_req(1'b0, 8'd0, "R9 no request while held");
        irq_in[6] = 1'b0;
        tick();
        irq_in[6] = 1'b1;
        tick();
        exp_req(1'b1, 8'd6, "R9 second edge pends");
        // R10 non-maskable
        nmi_in = 1'b1;
        tick();
        exp_req(1'b1, 8'hFF, "R10 nmi wins");
        ack();
        exp_req(1'b0, 8'd0, "R10 lines blocked during nmi");
        rd(ACT, 32'h0, "R10 nmi not a line");
        done(8'hFF);
        exp_req(1'b1, 8'd6, "R11 tail-chain after nmi");
        nmi_in = 1'b0;
        tick();
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule